// File: doc/BRIEF.md
# Paired-Byte Tuner Control Slave (Two-Wire Bus)

This block is a two-wire serial bus slave that programs a synthesised tuner. The slave samples the bus clock and data lines with a faster system clock and finds START and STOP conditions and bit edges from those samples. This lets it follow both standard-rate and fast-rate masters without stretching the clock. The slave address is a fixed five-bit prefix followed by two bits from a strap input. An address that does not match is never acknowledged, and the slave then ignores the bus until the next START.

In write mode the data bytes arrive in pairs. The top bit of the first byte of each pair selects what the pair carries. A 0 opens a frequency pair, which holds a 15-bit divider word. A 1 opens a control pair, which holds the reference-ratio code, the charge-pump level, the test selection and four single-bit controls. The divider word is applied atomically, so the loop never sees half of a new value. Any number of pairs may follow one address. In read mode the slave returns a status byte holding a power-on flag and a lock flag. It repeats that byte for as long as the master acknowledges.

Top module: `tuner_ctl_slave`

## Requirements
- R1: After reset the outputs are as follows: freq_word_o = 0, ref_code_o = 0, cp_level_o = 0, test_sel_o = 0, path_sel_o = 0, osc_sel_o = 0, gp_port_o = 0 and refout_en_o = 1. The power-on flag reads as 1.
- R2: The address byte is {prefix[4:0], addr_sel_i[1:0], rw}, sent MSB first. On a match the slave pulls SDA low (sda_oe_o = 1) during the acknowledge bit. On a mismatch it gives no acknowledge, ignores every following byte and changes no output until the next START.
- R3: In write mode (rw = 0) the slave acknowledges every complete data byte.
- R4: A first-of-pair byte with bit 7 = 0 is a frequency byte: bits 6:0 become freq_word_o[14:8]. The byte after it supplies freq_word_o[7:0].
- R5: A first-of-pair byte with bit 7 = 1 is control byte A: bits 6:5 go to cp_level_o and bits 4:0 go to ref_code_o, both applied at that byte. The byte after it is control byte B: bits 7:5 go to test_sel_o, bit 4 to path_sel_o, bit 3 to osc_sel_o, bit 2 to refout_en_o and bit 1 to gp_port_o. Bit 0 is ignored.
- R6: freq_word_o keeps its old value after a frequency high byte. It takes all 15 new bits together when the low byte completes. If a STOP or a START arrives before the low byte completes, the new high bits are applied and the old low bits are kept.
- R7: Pairs repeat after one address without re-addressing, and each one is decoded by R4 and R5. Pair position restarts at every START and STOP.
- R8: A STOP in the middle of a byte discards the partial byte. All data from earlier complete bytes is kept.
- R9: In read mode (rw = 1) the slave sends the status byte MSB first. It sends it again after each master acknowledge. After a master non-acknowledge it releases SDA until the next START, so the bus reads 0xFF.
- R10: The status byte is {por, lock, 6'b000000}. The por flag is set by reset. It is cleared by the STOP that ends a transaction in which at least one status byte was sent.
- R11: The lock bit of the status byte follows lock_i, sampled through the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel_i | input | 2 | Strap bits forming the low two address bits |
| lock_i | input | 1 | Loop lock indication from the synthesiser |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| freq_word_o | output | 15 | Divider word |
| ref_code_o | output | 5 | Reference ratio code |
| cp_level_o | output | 2 | Charge-pump current code |
| test_sel_o | output | 3 | Test mode selection |
| path_sel_o | output | 1 | Baseband path selection |
| osc_sel_o | output | 1 | Oscillator selection |
| refout_en_o | output | 1 | Buffered reference output enable |
| gp_port_o | output | 1 | General-purpose port |

## Verification
Random write transactions carry one to three pairs with random bytes, so both the frequency and the control decode are exercised. The leading bit of each byte is random, which shows whether pair steering alternates correctly. About one byte in ten is cut off by a STOP part-way through. This separates a design that keeps completed data from one that latches a partial shift register, and shows whether an orphan high frequency byte is committed. Directed cases cover these situations:
- a read held in frequency after only the high byte;
- prefix and strap mismatches, which must stay silent;
- a status read repeated under master acknowledge and then abandoned after a non-acknowledge;
- a power-on flag that must survive the first read and clear only at the STOP after it.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   localparam int BYTE_W    = 8;
   localparam int FREQ_W    = 15;
   localparam int FREQ_HI_W = FREQ_W - BYTE_W;
   localparam int REF_W     = 5;
   localparam int CP_W      = 2;
   localparam int TEST_W    = 3;
   localparam int CNT_W     = $clog2(BYTE_W + 1);
   localparam int CP_LSB    = REF_W;
   localparam int TEST_LSB  = BYTE_W - TEST_W;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_HALT
   } tcs_state_e;
endpackage

// File: rtl/tcs_sync_edge.sv
module tcs_sync_edge #(
   parameter int           STAGES  = 2,
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   logic [W-1:0] stg [STAGES];
   logic [W-1:0] prev_q;

   initial begin
      assert (STAGES >= 2) else $error("tcs_sync_edge: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= stg[STAGES-1];
   end

   assign q_o    = stg[STAGES-1];
   assign rise_o = q_o & ~prev_q;
   assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/tcs_bit_engine.sv
module tcs_bit_engine
   import tcs_pkg::*;
#(
   parameter int                 PFX_W  = 5,
   parameter int                 SEL_W  = 2,
   parameter logic [PFX_W-1:0]   PREFIX = 5'b11000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl,
   input  logic              sda,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic [SEL_W-1:0]  addr_sel,
   input  logic [BYTE_W-1:0] status_byte,
   output logic              sda_oe,
   output logic              byte_v,
   output logic [BYTE_W-1:0] byte_d,
   output logic              stop_p,
   output logic              seq_end,
   output logic              status_sent,
   output tcs_state_e        state_o
);
   initial begin
      assert (PFX_W + SEL_W == BYTE_W - 1) else $error("tcs_bit_engine: address fields must fill seven bits");
   end

   tcs_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] rx_q;
   logic [BYTE_W-1:0] tx_q;
   logic              rw_q;
   logic              mack_q;
   logic              start_c, stop_c;

   assign start_c = sda_fall & scl;
   assign stop_c  = sda_rise & scl;
   assign state_o = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         rx_q        <= '0;
         tx_q        <= '0;
         rw_q        <= 1'b0;
         mack_q      <= 1'b1;
         sda_oe      <= 1'b0;
         byte_v      <= 1'b0;
         byte_d      <= '0;
         stop_p      <= 1'b0;
         seq_end     <= 1'b0;
         status_sent <= 1'b0;
      end else begin
         byte_v      <= 1'b0;
         status_sent <= 1'b0;
         stop_p      <= stop_c;
         seq_end     <= stop_c | start_c;
         if (stop_c) begin
            state_q <= ST_IDLE;
            sda_oe  <= 1'b0;
         end else if (start_c) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            sda_oe  <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     rx_q  <= {rx_q[BYTE_W-2:0], sda};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                     if (state_q == ST_ADDR) begin
                        if (rx_q[BYTE_W-1:1] == {PREFIX, addr_sel}) begin
                           rw_q    <= rx_q[0];
                           state_q <= ST_AACK;
                           sda_oe  <= 1'b1;
                        end else begin
                           state_q <= ST_HALT;
                        end
                     end else begin
                        byte_v  <= 1'b1;
                        byte_d  <= rx_q;
                        state_q <= ST_WACK;
                        sda_oe  <= 1'b1;
                     end
                  end
               end
               ST_AACK, ST_WACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (state_q == ST_AACK && rw_q) begin
                        state_q <= ST_RDATA;
                        tx_q    <= status_byte;
                        sda_oe  <= ~status_byte[BYTE_W-1];
                     end else begin
                        state_q <= ST_WDATA;
                        sda_oe  <= 1'b0;
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                        state_q     <= ST_RACK;
                        sda_oe      <= 1'b0;
                        status_sent <= 1'b1;
                     end else begin
                        cnt_q  <= cnt_q + 1'b1;
                        tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_q[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack_q <= sda;
                  end else if (scl_fall) begin
                     if (!mack_q) begin
                        state_q <= ST_RDATA;
                        cnt_q   <= '0;
                        tx_q    <= status_byte;
                        sda_oe  <= ~status_byte[BYTE_W-1];
                     end else begin
                        state_q <= ST_HALT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/tcs_pair_regs.sv
module tcs_pair_regs
   import tcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_v,
   input  logic [BYTE_W-1:0] byte_d,
   input  logic              seq_end,
   output logic [FREQ_W-1:0] freq_o,
   output logic [REF_W-1:0]  ref_o,
   output logic [CP_W-1:0]   cp_o,
   output logic [TEST_W-1:0] test_o,
   output logic              path_o,
   output logic              osc_o,
   output logic              refout_o,
   output logic              gp_o
);
   initial begin
      assert (REF_W + CP_W < BYTE_W) else $error("tcs_pair_regs: control byte A overflows");
      assert (TEST_W + 4 <= BYTE_W) else $error("tcs_pair_regs: control byte B overflows");
   end

   logic                 second_q;
   logic                 freq_pair_q;
   logic                 hi_pend_q;
   logic [FREQ_HI_W-1:0] hi_stage_q;
   logic                 ctl_unused;

   assign ctl_unused = byte_d[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         second_q    <= 1'b0;
         freq_pair_q <= 1'b0;
         hi_pend_q   <= 1'b0;
         hi_stage_q  <= '0;
         freq_o      <= '0;
         ref_o       <= '0;
         cp_o        <= '0;
         test_o      <= '0;
         path_o      <= 1'b0;
         osc_o       <= 1'b0;
         refout_o    <= 1'b1;
         gp_o        <= 1'b0;
      end else if (byte_v) begin
         if (!second_q) begin
            second_q    <= 1'b1;
            freq_pair_q <= ~byte_d[BYTE_W-1];
            if (!byte_d[BYTE_W-1]) begin
               hi_stage_q <= byte_d[FREQ_HI_W-1:0];
               hi_pend_q  <= 1'b1;
            end else begin
               cp_o  <= byte_d[CP_LSB +: CP_W];
               ref_o <= byte_d[REF_W-1:0];
            end
         end else begin
            second_q <= 1'b0;
            if (freq_pair_q) begin
               freq_o    <= {hi_stage_q, byte_d};
               hi_pend_q <= 1'b0;
            end else begin
               test_o   <= byte_d[TEST_LSB +: TEST_W];
               path_o   <= byte_d[4];
               osc_o    <= byte_d[3];
               refout_o <= byte_d[2];
               gp_o     <= byte_d[1];
            end
         end
      end else if (seq_end) begin
         second_q  <= 1'b0;
         hi_pend_q <= 1'b0;
         if (hi_pend_q) freq_o[FREQ_W-1:BYTE_W] <= hi_stage_q;
      end
   end
endmodule

// File: rtl/tuner_ctl_slave.sv
module tuner_ctl_slave
   import tcs_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter int               PFX_W       = 5,
   parameter int               SEL_W       = 2,
   parameter logic [PFX_W-1:0] ADDR_PREFIX = 5'b11000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [SEL_W-1:0]  addr_sel_i,
   input  logic              lock_i,
   output logic              sda_oe_o,
   output logic [FREQ_W-1:0] freq_word_o,
   output logic [REF_W-1:0]  ref_code_o,
   output logic [CP_W-1:0]   cp_level_o,
   output logic [TEST_W-1:0] test_sel_o,
   output logic              path_sel_o,
   output logic              osc_sel_o,
   output logic              refout_en_o,
   output logic              gp_port_o
);
   logic [1:0]        bus_q, bus_rise, bus_fall;
   logic              scl_s, sda_s;
   logic              lock_s, lock_unused_r, lock_unused_f;
   logic              byte_v, stop_p, seq_end, status_sent;
   logic [BYTE_W-1:0] byte_d, status_byte;
   tcs_state_e        state;
   logic              por_q, read_seen_q;

   tcs_sync_edge #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}),
      .q_o(bus_q), .rise_o(bus_rise), .fall_o(bus_fall));

   tcs_sync_edge #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b0)) u_lock_sync (
      .clk(clk), .rst_n(rst_n), .d_i(lock_i),
      .q_o(lock_s), .rise_o(lock_unused_r), .fall_o(lock_unused_f));

   assign scl_s = bus_q[1];
   assign sda_s = bus_q[0];
   assign status_byte = {por_q, lock_s, {(BYTE_W-2){1'b0}}};

   tcs_bit_engine #(.PFX_W(PFX_W), .SEL_W(SEL_W), .PREFIX(ADDR_PREFIX)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .scl(scl_s), .sda(sda_s),
      .scl_rise(bus_rise[1]), .scl_fall(bus_fall[1]),
      .sda_rise(bus_rise[0]), .sda_fall(bus_fall[0]),
      .addr_sel(addr_sel_i), .status_byte(status_byte),
      .sda_oe(sda_oe_o), .byte_v(byte_v), .byte_d(byte_d),
      .stop_p(stop_p), .seq_end(seq_end), .status_sent(status_sent),
      .state_o(state));

   tcs_pair_regs u_regs (
      .clk(clk), .rst_n(rst_n), .byte_v(byte_v), .byte_d(byte_d), .seq_end(seq_end),
      .freq_o(freq_word_o), .ref_o(ref_code_o), .cp_o(cp_level_o), .test_o(test_sel_o),
      .path_o(path_sel_o), .osc_o(osc_sel_o), .refout_o(refout_en_o), .gp_o(gp_port_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_q       <= 1'b1;
         read_seen_q <= 1'b0;
      end else if (stop_p) begin
         if (read_seen_q) por_q <= 1'b0;
         read_seen_q <= 1'b0;
      end else if (status_sent) begin
         read_seen_q <= 1'b1;
      end
   end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
   import tcs_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              sda_oe,
   input tcs_state_e        state,
   input logic [FREQ_W-1:0] freq,
   input logic [13:0]       ctrl,
   input logic              byte_v,
   input logic              seq_end,
   input logic              stop_p,
   input logic              por
);
   // R2 / R9: the data line is only ever changed while the clock is low
   assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R2: no drive while idle or after a mismatch / non-acknowledge
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   assert_halt_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT) |-> !sda_oe);

   // R6: divider word moves only at a completed byte or at a sequence end
   assert_freq_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(freq) |-> $past(byte_v || seq_end));

   // R5 / R8: control fields move only on a completed byte
   assert_ctrl_on_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl) |-> $past(byte_v));

   // R10: power-on flag clears only at a STOP
   assert_por_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(por) |-> $past(stop_p));
endmodule

bind tuner_ctl_slave tcs_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o), .state(state),
   .freq(freq_word_o),
   .ctrl({ref_code_o, cp_level_o, test_sel_o, path_sel_o, osc_sel_o, refout_en_o, gp_port_o}),
   .byte_v(byte_v), .seq_end(seq_end), .stop_p(stop_p), .por(por_q));

// File: tb/tuner_ctl_slave_tb.sv
module tuner_ctl_slave_tb;
   localparam int         CLK_PERIOD = 10;
   localparam int         QTR        = 8;
   localparam logic [4:0] PFX        = 5'b11000;
   localparam logic [1:0] SEL        = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic lock = 1'b0;
   logic sda_oe, sda_bus;
   logic [14:0] freq_o;
   logic [4:0]  ref_o;
   logic [1:0]  cp_o;
   logic [2:0]  test_o;
   logic        path_o, osc_o, refout_o, gp_o;

   assign sda_bus = m_sda & ~sda_oe;
   always #(CLK_PERIOD/2) clk = ~clk;

   tuner_ctl_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .addr_sel_i(SEL), .lock_i(lock), .sda_oe_o(sda_oe),
      .freq_word_o(freq_o), .ref_code_o(ref_o), .cp_level_o(cp_o),
      .test_sel_o(test_o), .path_sel_o(path_o), .osc_sel_o(osc_o),
      .refout_en_o(refout_o), .gp_port_o(gp_o));

   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   // expected state
   logic [14:0] e_freq = '0;
   logic [4:0]  e_ref = '0;
   logic [1:0]  e_cp = '0;
   logic [2:0]  e_test = '0;
   logic        e_path = 0, e_osc = 0, e_refout = 1, e_gp = 0, e_por = 1;
   logic        m_second = 0, m_fpair = 0, m_pend = 0;
   logic [6:0]  m_hi = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [13:0] ctrl_now();
      return {ref_o, cp_o, test_o, path_o, osc_o, refout_o, gp_o};
   endfunction

   function automatic logic [13:0] ctrl_exp();
      return {e_ref, e_cp, e_test, e_path, e_osc, e_refout, e_gp};
   endfunction

   function automatic logic [7:0] status_exp(input logic p, input logic l);
      return {p, l, 6'b0};
   endfunction

   task automatic model_byte(input logic [7:0] d);
      if (!m_second) begin
         m_second = 1; m_fpair = ~d[7];
         if (!d[7]) begin m_hi = d[6:0]; m_pend = 1; end
         else begin e_cp = d[6:5]; e_ref = d[4:0]; end
      end else begin
         m_second = 0;
         if (m_fpair) begin e_freq = {m_hi, d}; m_pend = 0; end
         else begin
            e_test = d[7:5]; e_path = d[4]; e_osc = d[3]; e_refout = d[2]; e_gp = d[1];
         end
      end
   endtask

   task automatic model_end();
      if (m_pend) e_freq[14:8] = m_hi;
      m_pend = 0; m_second = 0;
   endtask

   task automatic hq();
      repeat (QTR) @(posedge clk);
      #1;
   endtask

   task automatic i2c_start();
      m_sda = 1; hq(); m_scl = 1; hq(); m_sda = 0; hq(); m_scl = 0; hq();
   endtask

   task automatic i2c_stop();
      m_sda = 0; hq(); m_scl = 1; hq(); m_sda = 1; hq(); hq();
   endtask

   task automatic wbit(input logic b);
      m_sda = b; hq(); m_scl = 1; hq(); hq(); m_scl = 0; hq();
   endtask

   task automatic rbit(output logic b);
      m_sda = 1; hq(); m_scl = 1; hq(); b = sda_bus; hq(); m_scl = 0; hq();
   endtask

   task automatic wbyte(input logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(ack);
   endtask

   task automatic rbyte(input logic mack, output logic [7:0] d);
      logic b;
      for (int i = 0; i < 8; i++) begin rbit(b); d = {d[6:0], b}; end
      wbit(mack);
   endtask

   task automatic check_all(input string tag);
      repeat (4) @(posedge clk);
      #1;
      chk({tag, " freq"}, 32'(freq_o), 32'(e_freq));
      chk({tag, " ctrl"}, 32'(ctrl_now()), 32'(ctrl_exp()));
   endtask

   task automatic read_txn(input int nbytes, input string tag);
      logic ack;
      logic [7:0] d;
      i2c_start();
      wbyte({PFX, SEL, 1'b1}, ack);
      chk({tag, " R2 read addr ack"}, 32'(ack), 0);
      for (int i = 0; i < nbytes; i++) begin
         rbyte((i == nbytes - 1), d);
         chk({tag, " R9 R10 R11 status"}, 32'(d), 32'(status_exp(e_por, lock)));
      end
      i2c_stop();
      e_por = 0;
   endtask

   task automatic rand_txn();
      logic ack;
      logic [7:0] d;
      int np;
      bit cut;
      cut = 0;
      i2c_start();
      wbyte({PFX, SEL, 1'b0}, ack);
      chk("R2 write addr ack", 32'(ack), 0);
      np = 1 + int'($urandom % 3);
      for (int p = 0; p < np && !cut; p++) begin
         for (int k = 0; k < 2 && !cut; k++) begin
            d = 8'($urandom);
            if ($urandom % 10 == 0) begin
               cut = 1;
               for (int i = 0; i < int'($urandom % 8); i++) wbit(d[7 - i]);
            end else begin
               wbyte(d, ack);
               chk("R3 data ack", 32'(ack), 0);
               model_byte(d);
               if (k == 0 && !d[7]) chk("R6 high byte held", 32'(freq_o), 32'(e_freq));
            end
         end
      end
      i2c_stop();
      model_end();
      check_all("R7 R8 random pairs");
   endtask

   initial begin
      logic ack;
      logic [7:0] d;
      void'($urandom(32'h5EED_1935));
      repeat (5) @(posedge clk);
      #1 rst_n = 1;
      repeat (5) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 reset freq", 32'(freq_o), 0);
      chk("R1 reset ctrl", 32'(ctrl_now()), 32'(14'b00000_00_000_0_0_1_0));
      chk("R1 reset drive", 32'(sda_oe), 0);

      // R9 R10: por survives repeated status bytes, cleared after stop
      i2c_start();
      wbyte({PFX, SEL, 1'b1}, ack);
      chk("R2 read addr ack", 32'(ack), 0);
      rbyte(1'b0, d); chk("R10 first status", 32'(d), 32'h80);
      rbyte(1'b1, d); chk("R9 repeated status", 32'(d), 32'h80);
      rbyte(1'b1, d); chk("R9 released after nack", 32'(d), 32'hFF);
      i2c_stop();
      e_por = 0;
      lock = 1;
      repeat (10) @(posedge clk);
      read_txn(1, "R11 locked");

      // R2 mismatches: strap and prefix
      i2c_start();
      wbyte({PFX, ~SEL, 1'b0}, ack);
      chk("R2 strap mismatch nack", 32'(ack), 1);
      wbyte(8'h85, ack);
      chk("R2 ignored data nack", 32'(ack), 1);
      i2c_stop();
      check_all("R2 strap mismatch");
      i2c_start();
      wbyte({PFX ^ 5'b00100, SEL, 1'b0}, ack);
      chk("R2 prefix mismatch nack", 32'(ack), 1);
      wbyte(8'h12, ack);
      wbyte(8'h34, ack);
      i2c_stop();
      check_all("R2 prefix mismatch");

      // R4 R5 R6 directed
      i2c_start();
      wbyte({PFX, SEL, 1'b0}, ack);
      wbyte(8'h7F, ack); model_byte(8'h7F);
      chk("R6 hold after high byte", 32'(freq_o), 0);
      wbyte(8'hA5, ack); model_byte(8'hA5);
      wbyte(8'hD5, ack); model_byte(8'hD5);
      wbyte(8'hAA, ack); model_byte(8'hAA);
      i2c_stop(); model_end();
      check_all("R4 R5 directed");
      chk("R4 full word", 32'(freq_o), 32'h7FA5);
      chk("R5 refout cleared", 32'(refout_o), 0);

      i2c_start();
      wbyte({PFX, SEL, 1'b0}, ack);
      wbyte(8'h2A, ack); model_byte(8'h2A);
      i2c_stop(); model_end();
      check_all("R6 high only at stop");
      chk("R6 high commit", 32'(freq_o), 32'h2AA5);

      // R8 partial bytes
      i2c_start();
      wbyte({PFX, SEL, 1'b0}, ack);
      wbyte(8'h11, ack); model_byte(8'h11);
      wbyte(8'h22, ack); model_byte(8'h22);
      for (int i = 0; i < 5; i++) wbit(1'b1);
      i2c_stop(); model_end();
      check_all("R8 cut after pair");
      i2c_start();
      wbyte({PFX, SEL, 1'b0}, ack);
      wbyte(8'h9E, ack); model_byte(8'h9E);
      for (int i = 0; i < 3; i++) wbit(1'b0);
      i2c_stop(); model_end();
      check_all("R8 cut inside control pair");

      // random mix
      for (int t = 0; t < 40; t++) begin
         if (t % 5 == 4) begin
            lock = 1'($urandom);
            repeat (10) @(posedge clk);
            read_txn(1 + int'($urandom % 2), "R11 random read");
         end else begin
            rand_txn();
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule